// File: doc/BRIEF.md
# RISC Integer Execute Unit

This block is the integer execute stage of a three-operand load/store processor pipeline. It receives an already decoded operation code together with two 32-bit register operands, a 16-bit immediate field and a 5-bit shift-amount field. From these it forms one 32-bit result in the same cycle. It covers wrapping add and subtract, add with an immediate, the four register bitwise operations, the three immediate bitwise operations, loading a constant into the upper half, and logical or arithmetic shifts. A shift amount comes either from the instruction field or from a register.

The unit also computes the effective address of a load or store. It uses the same adder for this, adding the base register to the sign-extended offset. How the immediate is widened depends on the operation. Arithmetic and address operations sign-extend it. Bitwise operations zero-extend it. The load-upper operation shifts it into the high half. An operation code outside the defined set gives a zero result and raises a flag, so the surrounding pipeline can raise an exception.

The unit is purely combinational. It holds no state and needs no clock.

Top module: `int_exec_unit`

## Requirements
- R1: Operation codes on `op_i` are 0 ADD, 1 SUB, 2 ADDI, 3 AND, 4 OR, 5 XOR, 6 NOR, 7 ANDI, 8 ORI, 9 XORI, 10 LUI, 11 SLL, 12 SRL, 13 SRA, 14 SLLV, 15 SRLV, 16 SRAV, 17 ADDR. ADD gives opa+opb and SUB gives opa-opb, both wrapping modulo 2^32 with no flag raised.
- R2: ADDI adds opa to `imm_i` read as a two's-complement value and sign-extended to 32 bits.
- R3: AND, OR, XOR and NOR combine opa and opb bitwise. NOR with opb equal to zero returns the bitwise inverse of opa.
- R4: ANDI, ORI and XORI combine opa with `imm_i` zero-extended to 32 bits, so bits 31:16 of the result equal opa[31:16] AND, OR or XOR zero.
- R5: LUI returns `imm_i` in bits 31:16 and zeros in bits 15:0. Applying ORI with a second immediate to that result yields the full 32-bit constant.
- R6: SLL, SRL and SRA shift opa by `shamt_i` and ignore opb. SLL fills the low bits with zeros and SRL fills the high bits with zeros.
- R7: SRA and SRAV fill the vacated high bits with copies of opa[31].
- R8: SLLV, SRLV and SRAV shift opa by opb[4:0]. They ignore opb[31:5] and `shamt_i`.
- R9: ADDR returns the effective address: opa (the base) plus the sign-extended 16-bit immediate offset, wrapping modulo 2^32.
- R10: Operation codes 18 to 31 drive `result_o` to zero and `illegal_o` to 1. Every defined code drives `illegal_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Decoded operation code (encoding in R1) |
| opa_i | input | 32 | First register operand; base for ADDR; value shifted by shifts |
| opb_i | input | 32 | Second register operand; amount source for variable shifts |
| imm_i | input | 16 | Immediate field of the instruction |
| shamt_i | input | 5 | Constant shift amount field |
| result_o | output | 32 | Execute result |
| illegal_o | output | 1 | High when `op_i` is not a defined operation |

## Verification
Every result and the illegal flag are due in the same cycle as the inputs that produce them, because no register lies on any path from an input to an output. The bench applies each operand set on a falling clock edge. It reads the outputs one time unit after the following rising edge, which gives the logic a full half period to settle before any comparison. The operand sets are chosen to hit the boundaries that matter here: wraparound at 2^32, negative immediates, the sign bit during an arithmetic shift, an amount of 31, an amount of zero, and register amounts with their upper bits set.

// File: rtl/exec_pkg.sv
package exec_pkg;

  localparam int unsigned OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,
    OP_SUB  = 5'd1,
    OP_ADDI = 5'd2,
    OP_AND  = 5'd3,
    OP_OR   = 5'd4,
    OP_XOR  = 5'd5,
    OP_NOR  = 5'd6,
    OP_ANDI = 5'd7,
    OP_ORI  = 5'd8,
    OP_XORI = 5'd9,
    OP_LUI  = 5'd10,
    OP_SLL  = 5'd11,
    OP_SRL  = 5'd12,
    OP_SRA  = 5'd13,
    OP_SLLV = 5'd14,
    OP_SRLV = 5'd15,
    OP_SRAV = 5'd16,
    OP_ADDR = 5'd17
  } exec_op_e;

  typedef enum logic [1:0] {
    SK_LEFT  = 2'd0,
    SK_RLOG  = 2'd1,
    SK_RARI  = 2'd2
  } shift_kind_e;

  typedef enum logic [1:0] {
    IMM_SIGN  = 2'd0,
    IMM_ZERO  = 2'd1,
    IMM_UPPER = 2'd2
  } imm_mode_e;

  typedef enum logic [1:0] {
    LF_AND = 2'd0,
    LF_OR  = 2'd1,
    LF_XOR = 2'd2,
    LF_NOR = 2'd3
  } logic_fn_e;

  typedef enum logic [2:0] {
    RS_ADDER = 3'd0,
    RS_LOGIC = 3'd1,
    RS_SHIFT = 3'd2,
    RS_IMM   = 3'd3,
    RS_NONE  = 3'd4
  } res_sel_e;

  typedef struct packed {
    res_sel_e    sel;
    logic        sub;
    logic        b_from_imm;
    imm_mode_e   imm_mode;
    logic_fn_e   lfn;
    shift_kind_e skind;
    logic        amt_from_reg;
    logic        bad_op;
  } exec_ctrl_t;

endpackage

// File: rtl/exec_ctrl.sv
module exec_ctrl
  import exec_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output exec_ctrl_t      ctrl_o
);

  always_comb begin
    ctrl_o              = '0;
    ctrl_o.sel          = RS_NONE;
    ctrl_o.imm_mode     = IMM_SIGN;
    ctrl_o.lfn          = LF_AND;
    ctrl_o.skind        = SK_LEFT;
    case (op_i)
      OP_ADD:  ctrl_o.sel = RS_ADDER;
      OP_SUB: begin
        ctrl_o.sel = RS_ADDER;
        ctrl_o.sub = 1'b1;
      end
      OP_ADDI, OP_ADDR: begin
        ctrl_o.sel        = RS_ADDER;
        ctrl_o.b_from_imm = 1'b1;
        ctrl_o.imm_mode   = IMM_SIGN;
      end
      OP_AND: begin ctrl_o.sel = RS_LOGIC; ctrl_o.lfn = LF_AND; end
      OP_OR:  begin ctrl_o.sel = RS_LOGIC; ctrl_o.lfn = LF_OR;  end
      OP_XOR: begin ctrl_o.sel = RS_LOGIC; ctrl_o.lfn = LF_XOR; end
      OP_NOR: begin ctrl_o.sel = RS_LOGIC; ctrl_o.lfn = LF_NOR; end
      OP_ANDI, OP_ORI, OP_XORI: begin
        ctrl_o.sel        = RS_LOGIC;
        ctrl_o.b_from_imm = 1'b1;
        ctrl_o.imm_mode   = IMM_ZERO;
        ctrl_o.lfn        = (op_i == OP_ANDI) ? LF_AND :
                            (op_i == OP_ORI)  ? LF_OR  : LF_XOR;
      end
      OP_LUI: begin
        ctrl_o.sel      = RS_IMM;
        ctrl_o.imm_mode = IMM_UPPER;
      end
      OP_SLL:  begin ctrl_o.sel = RS_SHIFT; ctrl_o.skind = SK_LEFT; end
      OP_SRL:  begin ctrl_o.sel = RS_SHIFT; ctrl_o.skind = SK_RLOG; end
      OP_SRA:  begin ctrl_o.sel = RS_SHIFT; ctrl_o.skind = SK_RARI; end
      OP_SLLV: begin
        ctrl_o.sel = RS_SHIFT; ctrl_o.skind = SK_LEFT; ctrl_o.amt_from_reg = 1'b1;
      end
      OP_SRLV: begin
        ctrl_o.sel = RS_SHIFT; ctrl_o.skind = SK_RLOG; ctrl_o.amt_from_reg = 1'b1;
      end
      OP_SRAV: begin
        ctrl_o.sel = RS_SHIFT; ctrl_o.skind = SK_RARI; ctrl_o.amt_from_reg = 1'b1;
      end
      default: begin
        ctrl_o.sel    = RS_NONE;
        ctrl_o.bad_op = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/exec_imm_ext.sv
module exec_imm_ext
  import exec_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IMM_W = 16
) (
  input  logic [IMM_W-1:0] imm_i,
  input  imm_mode_e        mode_i,
  output logic [XLEN-1:0]  ext_o
);

  localparam int unsigned PAD_W = XLEN - IMM_W;

  logic [XLEN-1:0] sign_ext;
  logic [XLEN-1:0] zero_ext;
  logic [XLEN-1:0] upper_ext;

  assign sign_ext  = {{PAD_W{imm_i[IMM_W-1]}}, imm_i};
  assign zero_ext  = {{PAD_W{1'b0}}, imm_i};
  assign upper_ext = {imm_i, {PAD_W{1'b0}}};

  always_comb begin
    case (mode_i)
      IMM_ZERO:  ext_o = zero_ext;
      IMM_UPPER: ext_o = upper_ext;
      default:   ext_o = sign_ext;
    endcase
  end

endmodule

// File: rtl/exec_adder.sv
module exec_adder #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            sub_i,
  output logic [XLEN-1:0] sum_o
);

  logic [XLEN-1:0] b_eff;
  logic [XLEN-1:0] carry_in;

  assign b_eff    = sub_i ? ~b_i : b_i;
  assign carry_in = {{(XLEN-1){1'b0}}, sub_i};
  assign sum_o    = a_i + b_eff + carry_in;

endmodule

// File: rtl/exec_logic.sv
module exec_logic
  import exec_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic_fn_e       fn_i,
  output logic [XLEN-1:0] y_o
);

  always_comb begin
    case (fn_i)
      LF_OR:   y_o = a_i | b_i;
      LF_XOR:  y_o = a_i ^ b_i;
      LF_NOR:  y_o = ~(a_i | b_i);
      default: y_o = a_i & b_i;
    endcase
  end

endmodule

// File: rtl/exec_shifter.sv
module exec_shifter
  import exec_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0]         a_i,
  input  logic [$clog2(XLEN)-1:0] amt_i,
  input  shift_kind_e             kind_i,
  output logic [XLEN-1:0]         y_o
);

  localparam int unsigned SHW = $clog2(XLEN);

  logic                       go_left;
  logic                       fill;
  logic [XLEN-1:0]            a_rev;
  logic [XLEN-1:0]            src;
  logic [XLEN-1:0]            res_rev;
  logic [SHW:0][XLEN-1:0]     stage;

  assign go_left = (kind_i == SK_LEFT);
  assign fill    = (kind_i == SK_RARI) & a_i[XLEN-1];

  // left shift reuses the right-shift network on bit-reversed data
  for (genvar i = 0; i < XLEN; i++) begin : g_rev
    assign a_rev[i]   = a_i[XLEN-1-i];
    assign res_rev[i] = stage[SHW][XLEN-1-i];
  end

  assign src      = go_left ? a_rev : a_i;
  assign stage[0] = src;

  for (genvar g = 0; g < SHW; g++) begin : g_stage
    localparam int unsigned STEP = 1 << g;
    assign stage[g+1] = amt_i[g] ?
                        {{STEP{fill}}, stage[g][XLEN-1:STEP]} :
                        stage[g];
  end

  assign y_o = go_left ? res_rev : stage[SHW];

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import exec_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IMM_W = 16
) (
  input  logic [OP_W-1:0]         op_i,
  input  logic [XLEN-1:0]         opa_i,
  input  logic [XLEN-1:0]         opb_i,
  input  logic [IMM_W-1:0]        imm_i,
  input  logic [$clog2(XLEN)-1:0] shamt_i,
  output logic [XLEN-1:0]         result_o,
  output logic                    illegal_o
);

  localparam int unsigned SHW = $clog2(XLEN);

  exec_ctrl_t        ctrl;
  logic [XLEN-1:0]   imm_ext;
  logic [XLEN-1:0]   b_sel;
  logic [XLEN-1:0]   add_y;
  logic [XLEN-1:0]   logic_y;
  logic [XLEN-1:0]   shift_y;
  logic [SHW-1:0]    shift_amt;

  exec_ctrl u_ctrl (
    .op_i   (op_i),
    .ctrl_o (ctrl)
  );

  exec_imm_ext #(.XLEN(XLEN), .IMM_W(IMM_W)) u_imm (
    .imm_i  (imm_i),
    .mode_i (ctrl.imm_mode),
    .ext_o  (imm_ext)
  );

  assign b_sel     = ctrl.b_from_imm ? imm_ext : opb_i;
  assign shift_amt = ctrl.amt_from_reg ? opb_i[SHW-1:0] : shamt_i;

  exec_adder #(.XLEN(XLEN)) u_add (
    .a_i   (opa_i),
    .b_i   (b_sel),
    .sub_i (ctrl.sub),
    .sum_o (add_y)
  );

  exec_logic #(.XLEN(XLEN)) u_logic (
    .a_i  (opa_i),
    .b_i  (b_sel),
    .fn_i (ctrl.lfn),
    .y_o  (logic_y)
  );

  exec_shifter #(.XLEN(XLEN)) u_shift (
    .a_i    (opa_i),
    .amt_i  (shift_amt),
    .kind_i (ctrl.skind),
    .y_o    (shift_y)
  );

  always_comb begin
    case (ctrl.sel)
      RS_ADDER: result_o = add_y;
      RS_LOGIC: result_o = logic_y;
      RS_SHIFT: result_o = shift_y;
      RS_IMM:   result_o = imm_ext;
      default:  result_o = '0;
    endcase
  end

  assign illegal_o = ctrl.bad_op;

endmodule

// File: rtl/exec_unit_chk.sv
module exec_unit_chk
  import exec_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IMM_W = 16
) (
  input logic [OP_W-1:0]         op_i,
  input logic [XLEN-1:0]         opa_i,
  input logic [XLEN-1:0]         opb_i,
  input logic [IMM_W-1:0]        imm_i,
  input logic [$clog2(XLEN)-1:0] shamt_i,
  input logic [XLEN-1:0]         result_o,
  input logic                    illegal_o
);

  localparam int unsigned PAD_W = XLEN - IMM_W;

  logic [XLEN-1:0] sext_imm;
  logic [XLEN-1:0] low_mask;

  assign sext_imm = {{PAD_W{imm_i[IMM_W-1]}}, imm_i};
  assign low_mask = ({{(XLEN-1){1'b0}}, 1'b1} << shamt_i) - 1'b1;

  always_comb begin
    // R1
    add_wrap_chk: assert (!(op_i == OP_ADD) || (result_o - opb_i == opa_i));
    // R1
    sub_wrap_chk: assert (!(op_i == OP_SUB) || (result_o + opb_i == opa_i));
    // R2
    addi_sext_chk: assert (!(op_i == OP_ADDI) || (result_o - opa_i == sext_imm));
    // R3
    nor_invert_chk: assert (!(op_i == OP_NOR && opb_i == '0) || (result_o == ~opa_i));
    // R4
    andi_upper_chk: assert (!(op_i == OP_ANDI) || (result_o[XLEN-1:IMM_W] == '0));
    // R4
    ori_upper_chk: assert (!(op_i == OP_ORI || op_i == OP_XORI) ||
                           (result_o[XLEN-1:IMM_W] == opa_i[XLEN-1:IMM_W]));
    // R5
    lui_place_chk: assert (!(op_i == OP_LUI) ||
                           (result_o[PAD_W-1:0] == '0 && result_o[XLEN-1:PAD_W] == imm_i));
    // R6
    sll_zero_fill_chk: assert (!(op_i == OP_SLL) || ((result_o & low_mask) == '0));
    // R7
    sra_sign_chk: assert (!(op_i == OP_SRA || op_i == OP_SRAV) ||
                          (result_o[XLEN-1] == opa_i[XLEN-1]));
    // R9
    addr_sum_chk: assert (!(op_i == OP_ADDR) || (result_o - opa_i == sext_imm));
    // R10
    illegal_zero_chk: assert (!illegal_o || (result_o == '0));
    // R10
    illegal_code_chk: assert (illegal_o == (op_i > OP_ADDR));
  end

endmodule

bind int_exec_unit exec_unit_chk #(.XLEN(XLEN), .IMM_W(IMM_W)) u_chk (
  .op_i      (op_i),
  .opa_i     (opa_i),
  .opb_i     (opb_i),
  .imm_i     (imm_i),
  .shamt_i   (shamt_i),
  .result_o  (result_o),
  .illegal_o (illegal_o)
);

// File: tb/sim_int_exec_unit.sv
`timescale 1ns/1ps
module sim_int_exec_unit;

  logic        clk;
  logic        rst_n;
  logic [4:0]  op;
  logic [31:0] opa;
  logic [31:0] opb;
  logic [15:0] imm;
  logic [4:0]  shamt;
  logic [31:0] result;
  logic        illegal;

  int checks;
  int errors;

  int_exec_unit u0 (
    .op_i      (op),
    .opa_i     (opa),
    .opb_i     (opb),
    .imm_i     (imm),
    .shamt_i   (shamt),
    .result_o  (result),
    .illegal_o (illegal)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive on falling edge, read one unit after the next rising edge
  task automatic apply(input logic [4:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] i, input logic [4:0] s);
    @(negedge clk);
    op = o; opa = a; opb = b; imm = i; shamt = s;
    @(posedge clk);
    #1;
  endtask

  task automatic t_idle;
    apply(5'd0, 32'h0, 32'h0, 16'h0, 5'd0);
    check("R1 idle result", result, 32'h0);
    check("R10 idle flag", {31'b0, illegal}, 32'h0);
  endtask

  task automatic t_arith;
    apply(5'd0, 32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0);
    check("R1 add wrap", result, 32'h0);
    check("R1 add no flag", {31'b0, illegal}, 32'h0);
    apply(5'd0, 32'h1234_5678, 32'h1111_1111, 16'h0, 5'd0);
    check("R1 add", result, 32'h2345_6789);
    apply(5'd1, 32'h0, 32'h1, 16'h0, 5'd0);
    check("R1 sub wrap", result, 32'hFFFF_FFFF);
    apply(5'd1, 32'h8000_0000, 32'h1, 16'h0, 5'd0);
    check("R1 sub", result, 32'h7FFF_FFFF);
  endtask

  task automatic t_addi;
    apply(5'd2, 32'h10, 32'hDEAD_BEEF, 16'hFFF4, 5'd0);
    check("R2 addi negative", result, 32'h4);
    apply(5'd2, 32'h0, 32'h0, 16'h7FFF, 5'd0);
    check("R2 addi positive", result, 32'h0000_7FFF);
    apply(5'd2, 32'h0, 32'h0, 16'h8000, 5'd0);
    check("R2 addi min", result, 32'hFFFF_8000);
  endtask

  task automatic t_reg_logic;
    apply(5'd3, 32'hF234_012F, 32'h0000_00FF, 16'h0, 5'd0);
    check("R3 and", result, 32'h0000_002F);
    apply(5'd4, 32'hF234_0000, 32'h0000_12BC, 16'h0, 5'd0);
    check("R3 or", result, 32'hF234_12BC);
    apply(5'd5, 32'hFF00_FF00, 32'h0FF0_0FF0, 16'h0, 5'd0);
    check("R3 xor", result, 32'hF0F0_F0F0);
    apply(5'd6, 32'h0F0F_00FF, 32'h0, 16'hFFFF, 5'd0);
    check("R3 nor invert", result, 32'hF0F0_FF00);
    apply(5'd6, 32'h0000_00F0, 32'h0000_000F, 16'h0, 5'd0);
    check("R3 nor", result, 32'hFFFF_FF00);
  endtask

  task automatic t_imm_logic;
    apply(5'd7, 32'hF234_012F, 32'hFFFF_FFFF, 16'h00FF, 5'd0);
    check("R4 andi", result, 32'h0000_002F);
    apply(5'd7, 32'hFFFF_FFFF, 32'h0, 16'h8001, 5'd0);
    check("R4 andi zext", result, 32'h0000_8001);
    apply(5'd8, 32'h1234_0000, 32'h0, 16'h8765, 5'd0);
    check("R4 ori", result, 32'h1234_8765);
    apply(5'd9, 32'hFFFF_0000, 32'h0, 16'hFFFF, 5'd0);
    check("R4 xori zext", result, 32'hFFFF_FFFF);
  endtask

  task automatic t_lui;
    logic [31:0] hi;
    apply(5'd10, 32'hAAAA_AAAA, 32'h5555_5555, 16'hFEDC, 5'd3);
    check("R5 lui", result, 32'hFEDC_0000);
    hi = result;
    apply(5'd8, hi, 32'h0, 16'h8765, 5'd0);
    check("R5 lui then ori", result, 32'hFEDC_8765);
  endtask

  task automatic t_const_shift;
    apply(5'd11, 32'h1, 32'h0000_0004, 16'h0, 5'd31);
    check("R6 sll by 31", result, 32'h8000_0000);
    apply(5'd11, 32'hFFFF_FFFF, 32'h0, 16'h0, 5'd4);
    check("R6 sll fill", result, 32'hFFFF_FFF0);
    apply(5'd12, 32'h8000_0000, 32'h0000_0001, 16'h0, 5'd4);
    check("R6 srl", result, 32'h0800_0000);
    apply(5'd12, 32'hDEAD_BEEF, 32'h1F, 16'h0, 5'd0);
    check("R6 srl by 0", result, 32'hDEAD_BEEF);
    apply(5'd13, 32'h8000_0000, 32'h0, 16'h0, 5'd4);
    check("R7 sra negative", result, 32'hF800_0000);
    apply(5'd13, 32'h4000_0000, 32'h0, 16'h0, 5'd2);
    check("R7 sra positive", result, 32'h1000_0000);
    apply(5'd13, 32'h8000_0000, 32'h0, 16'h0, 5'd31);
    check("R7 sra by 31", result, 32'hFFFF_FFFF);
  endtask

  task automatic t_var_shift;
    apply(5'd14, 32'h3, 32'hFFFF_FFE1, 16'h0, 5'd7);
    check("R8 sllv low bits", result, 32'h6);
    apply(5'd15, 32'hF000_0000, 32'h0000_001C, 16'h0, 5'd1);
    check("R8 srlv", result, 32'h0000_000F);
    apply(5'd16, 32'h8000_0000, 32'h0000_0020, 16'h0, 5'd5);
    check("R8 srav amount 32 is 0", result, 32'h8000_0000);
    apply(5'd16, 32'h8000_0010, 32'h0000_0004, 16'h0, 5'd0);
    check("R7 srav sign", result, 32'hF800_0001);
  endtask

  task automatic t_addr;
    apply(5'd17, 32'h0000_1000, 32'h0, 16'hFFFC, 5'd0);
    check("R9 addr negative offset", result, 32'h0000_0FFC);
    apply(5'd17, 32'h0, 32'h0, 16'h002C, 5'd0);
    check("R9 addr positive offset", result, 32'h0000_002C);
    apply(5'd17, 32'hFFFF_FFF0, 32'h0, 16'h0020, 5'd0);
    check("R9 addr wrap", result, 32'h0000_0010);
  endtask

  task automatic t_illegal;
    for (int c = 18; c < 32; c++) begin
      apply(c[4:0], 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 5'd31);
      check("R10 illegal result", result, 32'h0);
      check("R10 illegal flag", {31'b0, illegal}, 32'h1);
    end
    for (int c = 0; c < 18; c++) begin
      apply(c[4:0], 32'h1, 32'h1, 16'h1, 5'd1);
      check("R10 legal flag", {31'b0, illegal}, 32'h0);
    end
  endtask

  initial begin
    checks = 0;
    errors = 0;
    rst_n  = 1'b0;
    op = '0; opa = '0; opb = '0; imm = '0; shamt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_idle();
    t_arith();
    t_addi();
    t_reg_logic();
    t_imm_logic();
    t_lui();
    t_const_shift();
    t_var_shift();
    t_addr();
    t_illegal();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #50000;
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule